// File: doc/BRIEF.md
# Grouped Interrupt Priority Arbiter

This block sits in the per-processor slice of a small interrupt controller. For each source it receives a pending flag, an enable flag, a group flag and an 8-bit priority. It looks for the most urgent source that is both pending and enabled. The winner must pass two gates: the priority mask, which decides whether its ID is reported, and the running priority, which decides whether an interrupt line is raised.

In grouped mode, a winner in group 0 (group flag 0) can be routed to the fast-interrupt line. A winner in group 1 (group flag 1) always goes to the normal interrupt line. Routing depends on separate distributor-level and processor-interface-level enables for each group, and on a fast-interrupt routing control. A configuration input selects a simpler non-grouped mode, which drives only the normal interrupt line.

The arbiter walks the sources one per clock. At the end of each pass it registers the resulting line levels and the pending ID. The running priority is held in a register inside the block and is loaded through a write strobe.

Top module: `grp_prio_arb`

## Requirements
- R1: A synchronous active-high reset forces `irq_o` and `fiq_o` low, sets `pend_id` to 1023 and sets the running priority to 0xFF. After reset, a source of priority 0xFE below a mask of 0xFF raises an interrupt.
- R2: Only sources with both `src_pend` and `src_en` set compete. The smallest priority value wins. On equal values, the source with the lower index wins. `pend_id` is either 1023 or an index below NSRC.
- R3: The winner's index appears on `pend_id` only when its priority is strictly below `prio_mask`. Otherwise `pend_id` is 1023, and a `pend_id` of 1023 is never accompanied by a raised line.
- R4: A line is raised only when the winner's priority is also strictly below the running priority. The running priority is loaded from `run_prio_d` on a cycle with `run_prio_we` high. A winner that passes the mask but not the running priority is still reported on `pend_id`.
- R5: In grouped mode, a group-0 winner signals only when `dist_en_g0` is set, and a group-1 winner signals only when `dist_en_g1` is set.
- R6: In grouped mode, a group-0 winner drives `fiq_o` when `fiq_route` and `cpu_en_g0` are both set. Otherwise it drives `irq_o` when `cpu_en_g0` is set. A group-1 winner drives `irq_o` when `cpu_en_g1` is set.
- R7: In grouped mode, if both distributor group enables are clear, or both processor-interface group enables are clear, both lines are low and `pend_id` is 1023.
- R8: Grouped mode applies when `revision` is 2 or more, or when `sec_ext` is set. Otherwise the block works in non-grouped mode: the group flags are ignored, `fiq_o` stays low, `irq_o` requires `dist_en_g0` and `cpu_en_g0`, and with either of those clear `pend_id` is 1023.
- R9: Outputs change only on the last cycle of each NSRC-cycle pass, and `irq_o` and `fiq_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_pend | input | NSRC | Pending flag per source |
| src_en | input | NSRC | Enable flag per source |
| src_grp | input | NSRC | Group per source (0 or 1) |
| src_prio | input | NSRC*PW | Priority per source, source i at bits i*PW upward |
| prio_mask | input | PW | Priority mask |
| run_prio_we | input | 1 | Load strobe for the running priority |
| run_prio_d | input | PW | New running priority value |
| dist_en_g0 | input | 1 | Distributor enable, group 0 |
| dist_en_g1 | input | 1 | Distributor enable, group 1 |
| cpu_en_g0 | input | 1 | Processor-interface enable, group 0 |
| cpu_en_g1 | input | 1 | Processor-interface enable, group 1 |
| fiq_route | input | 1 | Route group 0 to the fast-interrupt line |
| revision | input | 4 | Architecture revision number |
| sec_ext | input | 1 | Security extensions present |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| pend_id | output | IDW | Reported pending source ID, 1023 for none |

## Verification
ID reporting and line signalling are decided at the same pass end. They split apart when the winner clears the mask but ties or exceeds the running priority. The bench forces this by loading a running priority equal to the winner's priority, then expects `pend_id` to show the winner while both lines stay low. A sweep of several hundred generated patterns, drawn from only four priority values so that ties and mask-equal cases are common, compares every pass against a reference computed in the bench across both modes and all enable combinations.

// File: rtl/grp_prio_arb.sv
module grp_prio_arb #(
  parameter int NSRC = 8,
  parameter int PW   = 8,
  parameter int IDW  = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    src_pend,
  input  logic [NSRC-1:0]    src_en,
  input  logic [NSRC-1:0]    src_grp,
  input  logic [NSRC*PW-1:0] src_prio,
  input  logic [PW-1:0]      prio_mask,
  input  logic               run_prio_we,
  input  logic [PW-1:0]      run_prio_d,
  input  logic               dist_en_g0,
  input  logic               dist_en_g1,
  input  logic               cpu_en_g0,
  input  logic               cpu_en_g1,
  input  logic               fiq_route,
  input  logic [3:0]         revision,
  input  logic               sec_ext,
  output logic               irq_o,
  output logic               fiq_o,
  output logic [IDW-1:0]     pend_id
);
  localparam int CW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [IDW-1:0] NONE = IDW'(1023);
  localparam logic [PW:0] NO_PRIO = {1'b1, {PW{1'b0}}};

  logic [CW-1:0] idx;
  logic [PW:0]   best_p;
  logic [CW-1:0] best_i;
  logic          best_g;
  logic [PW-1:0] run_prio;

  wire scan_first = (idx == '0);
  wire scan_last  = (idx == CW'(NSRC - 1));

  wire [PW:0]   base_p = scan_first ? NO_PRIO : best_p;
  wire [PW-1:0] cur_p  = src_prio[idx*PW +: PW];
  wire cand = src_pend[idx] & src_en[idx] & ({1'b0, cur_p} < base_p);

  wire [PW:0]   win_p = cand ? {1'b0, cur_p} : base_p;
  wire [CW-1:0] win_i = cand ? idx : best_i;
  wire          win_g = cand ? src_grp[idx] : best_g;

  wire grouped = (revision >= 4'd2) | sec_ext;
  wire fwd     = win_p < {1'b0, prio_mask};
  wire urgent  = win_p < {1'b0, run_prio};

  wire g_off   = (~dist_en_g0 & ~dist_en_g1) | (~cpu_en_g0 & ~cpu_en_g1);
  wire g_dist  = win_g ? dist_en_g1 : dist_en_g0;
  wire g_take  = ~g_off & fwd & g_dist & urgent;
  wire to_fiq  = ~win_g & fiq_route;
  wire g_fiq   = g_take & to_fiq & cpu_en_g0;
  wire g_irq   = g_take & ~to_fiq & (win_g ? cpu_en_g1 : cpu_en_g0);

  wire p_off   = ~dist_en_g0 | ~cpu_en_g0;
  wire p_irq   = ~p_off & fwd & urgent;

  wire off     = grouped ? g_off : p_off;
  wire n_irq   = grouped ? g_irq : p_irq;
  wire n_fiq   = grouped & g_fiq;
  wire [IDW-1:0] n_id = (~off & fwd) ? IDW'(win_i) : NONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      best_p   <= NO_PRIO;
      best_i   <= '0;
      best_g   <= 1'b0;
      run_prio <= '1;
      irq_o    <= 1'b0;
      fiq_o    <= 1'b0;
      pend_id  <= NONE;
    end else begin
      idx    <= scan_last ? '0 : idx + 1'b1;
      best_p <= win_p;
      best_i <= win_i;
      best_g <= win_g;
      if (run_prio_we) run_prio <= run_prio_d;
      if (scan_last) begin
        irq_o   <= n_irq;
        fiq_o   <= n_fiq;
        pend_id <= n_id;
      end
    end
  end
endmodule

// File: rtl/grp_prio_arb_chk.sv
module grp_prio_arb_chk #(
  parameter int NSRC = 8,
  parameter int IDW  = 10
) (
  input logic           clk,
  input logic           rst,
  input logic           irq_o,
  input logic           fiq_o,
  input logic [IDW-1:0] pend_id,
  input logic           scan_last
);
  localparam logic [IDW-1:0] NONE = IDW'(1023);

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (pend_id == NONE && !irq_o && !fiq_o));

  assert_id_range_R2: assert property (@(posedge clk) disable iff (rst)
    (pend_id == NONE) || (pend_id < IDW'(NSRC)));

  assert_quiet_none_R3: assert property (@(posedge clk) disable iff (rst)
    (pend_id == NONE) |-> (!irq_o && !fiq_o));

  assert_one_line_R9: assert property (@(posedge clk) disable iff (rst)
    !(irq_o && fiq_o));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !scan_last |=> ($stable(irq_o) && $stable(fiq_o) && $stable(pend_id)));
endmodule

bind grp_prio_arb grp_prio_arb_chk #(.NSRC(NSRC), .IDW(IDW)) chk (
  .clk(clk), .rst(rst), .irq_o(irq_o), .fiq_o(fiq_o),
  .pend_id(pend_id), .scan_last(scan_last)
);

// File: tb/grp_prio_arb_test.sv
module grp_prio_arb_test;
  localparam int N = 4;
  localparam int PW = 8;
  localparam int IDW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] pend = '0, en = '0, grp = '0;
  logic [N*PW-1:0] prio = '0;
  logic [PW-1:0] mask = '0, rp_d = '0;
  logic rp_we = 1'b0;
  logic dg0 = 0, dg1 = 0, cg0 = 0, cg1 = 0, froute = 0, sext = 0;
  logic [3:0] rev = '0;
  logic irq, fiq;
  logic [IDW-1:0] pid;

  int checks = 0, errors = 0;
  logic [PW-1:0] model_rp = 8'hFF;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  grp_prio_arb #(.NSRC(N), .PW(PW), .IDW(IDW)) uut (
    .clk(clk), .rst(rst), .src_pend(pend), .src_en(en), .src_grp(grp),
    .src_prio(prio), .prio_mask(mask), .run_prio_we(rp_we), .run_prio_d(rp_d),
    .dist_en_g0(dg0), .dist_en_g1(dg1), .cpu_en_g0(cg0), .cpu_en_g1(cg1),
    .fiq_route(froute), .revision(rev), .sec_ext(sext),
    .irq_o(irq), .fiq_o(fiq), .pend_id(pid)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic set_rp(input logic [PW-1:0] v);
    rp_d = v; rp_we = 1'b1;
    @(negedge clk);
    rp_we = 1'b0;
    model_rp = v;
  endtask

  task automatic settle();
    repeat (2*N + 2) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input int e_irq, input int e_fiq, input int e_id);
    chk({tag, " irq"}, int'(irq), e_irq);
    chk({tag, " fiq"}, int'(fiq), e_fiq);
    chk({tag, " id"}, int'(pid), e_id);
  endtask

  task automatic model(output int m_irq, output int m_fiq, output int m_id);
    int bp = 256, bi = 0, bg = 0;
    bit grouped, off, fwd, take;
    for (int i = 0; i < N; i++) begin
      int p = int'(prio[i*PW +: PW]);
      if (pend[i] && en[i] && p < bp) begin bp = p; bi = i; bg = grp[i]; end
    end
    grouped = (rev >= 2) || sext;
    fwd = bp < int'(mask);
    m_irq = 0; m_fiq = 0;
    if (grouped) begin
      off = (!dg0 && !dg1) || (!cg0 && !cg1);
      take = !off && fwd && (bg ? dg1 : dg0) && bp < int'(model_rp);
      if (take && bg == 0 && froute) m_fiq = cg0;
      else if (take) m_irq = bg ? cg1 : cg0;
    end else begin
      off = !dg0 || !cg0;
      m_irq = (!off && fwd && bp < int'(model_rp)) ? 1 : 0;
    end
    m_id = (!off && fwd) ? bi : 1023;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int ei, ef, eid;
    repeat (3) @(negedge clk);
    expect_out("R1 reset", 0, 0, 1023);
    rst = 1'b0;

    // R1: running priority resets to 0xFF
    rev = 4'd2; dg0 = 1; dg1 = 1; cg0 = 1; cg1 = 1; mask = 8'hFF;
    pend = 4'b0001; en = 4'b0001; grp = 4'b0001; prio = {8'h00, 8'h00, 8'h00, 8'hFE};
    settle(); expect_out("R1 run prio FF", 1, 0, 0);

    // R2: tie, lowest index wins; disabled/nonpending ignored
    pend = 4'b1110; en = 4'b1011; grp = 4'b1111;
    prio = {8'h10, 8'h05, 8'h20, 8'h10};
    settle(); expect_out("R2 tie/qualify", 1, 0, 3);
    prio = {8'h10, 8'h05, 8'h10, 8'h01};
    settle(); expect_out("R2 tie low index", 1, 0, 1);

    // R3: mask equal blocks
    mask = 8'h10;
    settle(); expect_out("R3 mask equal", 0, 0, 1023);

    // R4: running priority equal -> reported, not signalled
    mask = 8'hFF; set_rp(8'h10);
    settle(); expect_out("R4 run prio equal", 0, 0, 1);
    set_rp(8'h11);
    settle(); expect_out("R4 run prio above", 1, 0, 1);
    set_rp(8'hFF);

    // R5 / R6: group 0 routing
    grp = 4'b0000; froute = 1;
    settle(); expect_out("R6 fiq route", 0, 1, 1);
    dg0 = 0;
    settle(); expect_out("R5 dist g0 off", 0, 0, 1);
    dg0 = 1; cg0 = 0;
    settle(); expect_out("R6 fiq needs cpu g0", 0, 0, 1);
    cg0 = 1; froute = 0;
    settle(); expect_out("R6 g0 to irq", 1, 0, 1);

    // R7: both cpu enables clear
    cg0 = 0; cg1 = 0;
    settle(); expect_out("R7 cpu both off", 0, 0, 1023);
    cg0 = 1; cg1 = 1; dg0 = 0; dg1 = 0;
    settle(); expect_out("R7 dist both off", 0, 0, 1023);

    // R8: non-grouped mode, fiq never, group ignored
    dg0 = 1; dg1 = 0; rev = 4'd1; sext = 0; froute = 1; grp = 4'b1111;
    settle(); expect_out("R8 plain irq", 1, 0, 1);
    sext = 1;
    settle(); expect_out("R8 sec_ext grouped", 0, 0, 1);

    // R2-R8 sweep against reference
    for (int it = 0; it < 600; it++) begin
      logic [31:0] r = rnd(), q = rnd(), s = rnd();
      pend = r[3:0]; en = r[7:4]; grp = r[11:8];
      for (int i = 0; i < N; i++) prio[i*PW +: PW] = 8'(((q >> (2*i)) & 3) * 8'h20 + 8'h10);
      mask = 8'(((s[1:0]) * 8'h20) + 8'h30);
      dg0 = r[12]; dg1 = r[13]; cg0 = r[14]; cg1 = r[15]; froute = r[16];
      rev = 4'(r[18:17]); sext = r[19];
      if (r[20]) set_rp(8'(((s[3:2]) * 8'h20) + 8'h10));
      settle();
      model(ei, ef, eid);
      expect_out("R2/R3/R4/R5/R6/R7/R8 sweep", ei, ef, eid);
      chk("R9 one line", int'(irq && fiq), 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule